// File: doc/BRIEF.md
# Token-Loss Reconfiguration Timer

This block sits beside the receiver of a node on a token-passing network. It watches a line-activity strobe and decides when the token has been lost and when this node should start rebuilding the network. The timing runs in two phases. First, a fixed idle-line watch declares the token lost once the line has stayed quiet for longer than a set limit. Second, a backoff timer whose length depends on the node runs for a time proportional to 255 minus the node's 8-bit ID. Because of this, the node with the highest ID finishes its backoff first and is the one that sends the first invitation to transmit, which it addresses to itself.

Time is measured in ticks of a clock-enable input. With the default values of `IDLE_US` = 82 and `UNIT_US` = 146, and with `TICKS_PER_US` ticks per microsecond, the block meets the timing needed for the 2.5 Mbps line rate. Smaller values shorten every interval in proportion. The controller has three states:

- WATCH: counts idle ticks.
- BACKOFF: counts the node-specific delay.
- FIRE: lasts one cycle and raises the start pulse.

It moves between them as follows:

- WATCH goes to BACKOFF on idle expiry.
- WATCH goes directly to FIRE on idle expiry when the backoff is zero.
- BACKOFF goes to FIRE when the backoff is complete.
- BACKOFF goes back to WATCH on line activity.
- FIRE always goes back to WATCH.

Top module: `token_loss_timer`

## Requirements
- R1: During and right after reset, `token_lost` and `recon_start` are 0 and the controller is in WATCH with its idle count at zero.
- R2: Let IDLE_LIM = IDLE_US*TICKS_PER_US. The token is declared lost on the (IDLE_LIM+1)-th consecutive idle tick after the last line activity. `token_lost` is 1 from the next cycle onward.
- R3: After the loss, `recon_start` pulses once the line has seen a further UNIT_US*TICKS_PER_US*(255-node_id) idle ticks. Counted from the last activity, this is after IDLE_LIM+1+UNIT_US*TICKS_PER_US*(255-node_id) idle ticks.
- R4: For a node_id of 255 the backoff is zero, and `recon_start` is high in the cycle right after the loss is detected, which is the same cycle in which `token_lost` first reads 1.
- R5: `recon_start` is high for exactly one cycle. Afterwards the controller is in WATCH with its idle count at zero, so no further pulse can come within IDLE_LIM idle ticks.
- R6: Line activity during WATCH resets the idle count to zero. If activity arrives after IDLE_LIM idle ticks, no loss is declared.
- R7: Line activity during BACKOFF cancels the backoff without a pulse and returns the controller to WATCH. The next pulse then needs a complete new idle period and backoff.
- R8: `token_lost` stays at 1 through line activity and through pulses, and clears only in the cycle after `clr_lost` is asserted.
- R9: Only cycles with `tick` high advance either timer. Cycles without a tick change no count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Time-base enable; one tick is 1/TICKS_PER_US µs |
| line_act | input | 1 | High in a cycle in which the receiver saw line activity |
| node_id | input | 8 | ID of this node; 255 has the shortest backoff |
| clr_lost | input | 1 | Clears the sticky lost-token flag |
| token_lost | output | 1 | Sticky flag: the token was found lost |
| recon_start | output | 1 | One-cycle pulse: begin network reconfiguration |

## Verification
The assertions check, on every cycle, the rules that are local in time:

- the start pulse is never wider than one cycle;
- the lost flag only ever rises after an idle expiry, and it holds until it is cleared;
- activity during the backoff suppresses the next pulse;
- a node with ID 255 fires on the cycle right after detection;
- neither timer finishes on a cycle without a tick.

The absolute lengths of the idle period and of the backoff for each node ID can only be shown by the bench's scenarios. The same holds for a restart after a cancel and for counting that stays correct under a sparse tick. The bench measures these in ticks from the last activity and compares them with the arithmetic in R2 and R3.

// File: rtl/tlt_pkg.sv
package tlt_pkg;
    typedef enum logic [1:0] {
        ST_WATCH   = 2'd0,
        ST_BACKOFF = 2'd1,
        ST_FIRE    = 2'd2
    } tlt_state_e;
endpackage

// File: rtl/tlt_idle_watch.sv
module tlt_idle_watch #(
    parameter int IDLE_LIM = 82
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic tick,
    input  logic line_act,
    output logic expire
);
    localparam int IW = $clog2(IDLE_LIM + 1);
    localparam logic [IW-1:0] LIM = IW'(IDLE_LIM);

    logic [IW-1:0] idle_cnt;

    // An expiry takes one more idle tick after the count has reached the limit.
    assign expire = enable && tick && !line_act && (idle_cnt == LIM);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idle_cnt <= '0;
        end else if (!enable || line_act || expire) begin
            idle_cnt <= '0;
        end else if (tick) begin
            idle_cnt <= idle_cnt + IW'(1);
        end
    end
endmodule

// File: rtl/tlt_backoff.sv
module tlt_backoff #(
    parameter int UNIT_TICKS = 146
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       tick,
    input  logic       line_act,
    input  logic [7:0] node_id,
    output logic       zero,
    output logic       done
);
    localparam int MAX_BO = UNIT_TICKS * 255;
    localparam int BW     = $clog2(MAX_BO + 1);

    logic [BW-1:0] target;
    logic [BW-1:0] bo_cnt;

    assign target = BW'(UNIT_TICKS) * BW'(8'hFF - node_id);
    assign zero   = (target == '0);
    assign done   = run && tick && !line_act && ((bo_cnt + BW'(1)) == target);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bo_cnt <= '0;
        end else if (!run || line_act || done) begin
            bo_cnt <= '0;
        end else if (tick) begin
            bo_cnt <= bo_cnt + BW'(1);
        end
    end
endmodule

// File: rtl/tlt_fsm.sv
module tlt_fsm
    import tlt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic idle_exp,
    input  logic bo_zero,
    input  logic bo_done,
    input  logic line_act,
    input  logic clr_lost,
    output logic watch_en,
    output logic bo_run,
    output logic recon_start,
    output logic token_lost
);
    tlt_state_e state_q, state_d;
    logic       lost_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_WATCH;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WATCH: begin
                if (idle_exp) state_d = bo_zero ? ST_FIRE : ST_BACKOFF;
            end
            ST_BACKOFF: begin
                if (line_act)     state_d = ST_WATCH;
                else if (bo_done) state_d = ST_FIRE;
            end
            ST_FIRE: state_d = ST_WATCH;
            default: state_d = ST_WATCH;
        endcase
    end

    always_comb begin
        watch_en    = (state_q == ST_WATCH);
        bo_run      = (state_q == ST_BACKOFF);
        recon_start = (state_q == ST_FIRE);
    end

    // A detection in the same cycle as a clear takes precedence over the clear.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        lost_q <= 1'b0;
        else if (idle_exp) lost_q <= 1'b1;
        else if (clr_lost) lost_q <= 1'b0;
    end

    assign token_lost = lost_q;
endmodule

// File: rtl/token_loss_timer.sv
module token_loss_timer #(
    parameter int TICKS_PER_US = 1,
    parameter int IDLE_US      = 82,
    parameter int UNIT_US      = 146
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       line_act,
    input  logic [7:0] node_id,
    input  logic       clr_lost,
    output logic       token_lost,
    output logic       recon_start
);
    localparam int IDLE_LIM   = IDLE_US * TICKS_PER_US;
    localparam int UNIT_TICKS = UNIT_US * TICKS_PER_US;

    logic watch_en, bo_run, idle_exp, bo_zero, bo_done;

    tlt_idle_watch #(.IDLE_LIM(IDLE_LIM)) u_idle (
        .clk(clk), .rst_n(rst_n), .enable(watch_en), .tick(tick),
        .line_act(line_act), .expire(idle_exp)
    );

    tlt_backoff #(.UNIT_TICKS(UNIT_TICKS)) u_bo (
        .clk(clk), .rst_n(rst_n), .run(bo_run), .tick(tick),
        .line_act(line_act), .node_id(node_id), .zero(bo_zero), .done(bo_done)
    );

    tlt_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .idle_exp(idle_exp), .bo_zero(bo_zero),
        .bo_done(bo_done), .line_act(line_act), .clr_lost(clr_lost),
        .watch_en(watch_en), .bo_run(bo_run), .recon_start(recon_start),
        .token_lost(token_lost)
    );
endmodule

// File: rtl/tlt_checker.sv
module tlt_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       tick,
    input logic       line_act,
    input logic [7:0] node_id,
    input logic       clr_lost,
    input logic       idle_exp,
    input logic       bo_run,
    input logic       bo_done,
    input logic       token_lost,
    input logic       recon_start
);
    assert_pulse_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        recon_start |=> !recon_start);

    assert_lost_from_expiry_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(token_lost) |-> $past(idle_exp));

    assert_lost_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (token_lost && !clr_lost) |=> token_lost);

    assert_lost_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_lost && !idle_exp) |=> !token_lost);

    assert_cancel_backoff_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bo_run && line_act) |=> !recon_start);

    assert_top_id_fires_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_exp && node_id == 8'hFF) |=> recon_start);

    assert_idle_needs_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
        idle_exp |-> (tick && !line_act));

    assert_backoff_needs_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bo_done |-> (tick && !line_act));

    always_comb begin
        if (rst_n === 1'b0) begin
            assert_reset_quiet_R1: assert (!recon_start);
        end
    end
endmodule

bind token_loss_timer tlt_checker u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .line_act(line_act),
    .node_id(node_id), .clr_lost(clr_lost), .idle_exp(idle_exp),
    .bo_run(bo_run), .bo_done(bo_done), .token_lost(token_lost),
    .recon_start(recon_start)
);

// File: tb/token_loss_timer_bench.sv
module token_loss_timer_bench;
    localparam int TPU  = 2;
    localparam int IDLE = 4;
    localparam int UNIT = 1;
    localparam int LIM  = IDLE * TPU;
    localparam int UT   = UNIT * TPU;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       line_act = 1'b0;
    logic [7:0] node_id = 8'd0;
    logic       clr_lost = 1'b0;
    logic       token_lost, recon_start;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    token_loss_timer #(.TICKS_PER_US(TPU), .IDLE_US(IDLE), .UNIT_US(UNIT)) u_token_loss_timer (
        .clk(clk), .rst_n(rst_n), .tick(tick), .line_act(line_act),
        .node_id(node_id), .clr_lost(clr_lost),
        .token_lost(token_lost), .recon_start(recon_start)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_flag();
        @(negedge clk);
        tick = 1'b0; clr_lost = 1'b1;
        @(negedge clk);
        clr_lost = 1'b0;
    endtask

    // One cycle of line activity, then `stop` idle ticks with one tick every `per` cycles.
    task automatic run_idle(input int id, input int per, input int stop,
                            output int lost_at, output int rec_at,
                            output int pulses, output bit wide, output bit lost0);
        bit prev;
        int ticks, cyc;
        node_id = 8'(id);
        @(negedge clk);
        line_act = 1'b1; tick = 1'b1;
        @(negedge clk);
        line_act = 1'b0;
        lost0 = token_lost;
        ticks = 0; cyc = 0; lost_at = -1; rec_at = -1; pulses = 0; wide = 1'b0; prev = 1'b0;
        while (ticks < stop) begin
            tick = ((cyc % per) == 0);
            if (tick) ticks++;
            cyc++;
            @(negedge clk);
            if (token_lost && lost_at < 0) lost_at = ticks;
            if (recon_start) begin
                pulses++;
                if (rec_at < 0) rec_at = ticks;
                if (prev) wide = 1'b1;
            end
            prev = recon_start;
        end
        tick = 1'b0;
    endtask

    task automatic full_seq(input int id, input int per);
        int la, ra, np, exp_t;
        bit wd, l0;
        exp_t = LIM + 1 + UT * (255 - id);
        clear_flag();
        run_idle(id, per, exp_t + 2, la, ra, np, wd, l0);
        chk(la == LIM + 1, "R2 loss tick", la, LIM + 1);
        chk(ra == exp_t, "R3 backoff tick", ra, exp_t);
        chk(np == 1 && !wd, "R5 single pulse", np, 1);
        if (id == 255) chk(ra == la, "R4 top id fires next cycle", ra, la);
    endtask

    initial begin
        int la, ra, np;
        bit wd, l0;
        #3;
        @(negedge clk);
        chk(token_lost == 1'b0, "R1 reset lost", int'(token_lost), 0);
        chk(recon_start == 1'b0, "R1 reset pulse", int'(recon_start), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(token_lost == 1'b0 && recon_start == 1'b0, "R1 after reset", int'(token_lost), 0);

        for (int id = 0; id < 256; id++) begin
            if (id % 9 == 0 || id >= 245) full_seq(id, 1);
        end
        // R9: sparse tick, results must be the same in ticks
        full_seq(255, 3);
        full_seq(250, 3);
        full_seq(131, 2);

        // R6: activity just before expiry prevents the loss
        clear_flag();
        run_idle(200, 1, LIM, la, ra, np, wd, l0);
        chk(la == -1, "R6 no loss before limit", la, -1);
        run_idle(200, 1, LIM + 1, la, ra, np, wd, l0);
        chk(la == LIM + 1, "R6 loss after restart", la, LIM + 1);

        // R7/R8: cancel in backoff, flag sticky through activity
        clear_flag();
        run_idle(100, 1, LIM + 1 + 50, la, ra, np, wd, l0);
        chk(np == 0, "R7 no pulse before cancel", np, 0);
        run_idle(100, 1, LIM + 1 + UT * 155 + 2, la, ra, np, wd, l0);
        chk(l0 == 1'b1, "R8 flag survives activity", int'(l0), 1);
        chk(ra == LIM + 1 + UT * 155, "R7 restart after cancel", ra, LIM + 1 + UT * 155);
        chk(token_lost == 1'b1, "R8 flag survives pulse", int'(token_lost), 1);
        clear_flag();
        chk(token_lost == 1'b0, "R8 clear", int'(token_lost), 0);

        // R5: after a pulse, no new pulse within LIM idle ticks
        clear_flag();
        run_idle(255, 1, 2 * LIM + 1, la, ra, np, wd, l0);
        chk(np == 1, "R5 back to watch after pulse", np, 1);

        // R9: no ticks, no progress
        clear_flag();
        run_idle(255, 1, 0, la, ra, np, wd, l0);
        repeat (100) @(negedge clk);
        chk(token_lost == 1'b0 && recon_start == 1'b0, "R9 frozen without tick", int'(token_lost), 0);

        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule